// File: doc/BRIEF.md
# USB host transaction error tracker

This block sits beside a host controller's transaction engine and scores the
result of every finished transaction against one queue head. Each completion
strobe carries an outcome code with its context: the token kind, whether the
endpoint runs at high speed, whether the transaction was a complete-split,
the handshake seen, and the received and maximum byte counts. From these the
block decides whether a transaction error occurred, spends one unit of the
queue's error budget, detects babble and halts the queue.

The error budget is a small down-counter loaded by a reload strobe. When it
steps from one to zero the queue halts and a sticky error interrupt status bit
is raised. Software clears that bit by writing a one to it. A budget of zero at
load time means unlimited retries. A halted queue ignores all completions until
the next reload.

Top module: `usb_xact_err_tracker`

## Requirements
- R1: On a completion (`done`=1) with outcome CRC (1), TIMEOUT (2) or BADPID (3), `xact_err` is set and `err_cnt` drops by one in the next cycle.
- R2: For outcome HANDSHAKE (4) with `is_setup`=1 and `hs_ep`=1, a handshake of NAK (1) or NYET (2) is an error with the effects of R1.
- R3: For outcome HANDSHAKE with `hs_ep`=0 and `csplit`=1, a NAK is an error with the effects of R1. Every other handshake combination changes nothing; handshake codes are ACK=0, NAK=1, NYET=2, STALL=3.
- R4: When an error moves `err_cnt` from 1 to 0, `halted` and `err_irq` both become 1 in the same cycle.
- R5: For outcome DATA (5), `byte_cnt` > `max_len` sets `babble` and `halted` without changing `err_cnt`. `byte_cnt` <= `max_len` changes nothing.
- R6: Outcome OK (0), and the unused codes 6 and 7, leave the counter and all flags unchanged.
- R7: `err_irq` holds until `sw_clr`=1 clears it. When a clear and a new set fall in the same cycle, the bit stays 1.
- R8: While `halted`=1, completions have no effect. `reload` loads `err_cnt` from `reload_cnt` and clears `halted`, `xact_err` and `babble`, but not `err_irq`. `reload` takes priority over a same-cycle completion.
- R9: After a reload with `reload_cnt`=0, errors set `xact_err` but never decrement, halt or raise `err_irq`.
- R10: After reset, `err_cnt` equals RESET_CNT (default 3), the budget is limited, and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| done | input | 1 | Transaction completion strobe |
| outcome | input | 3 | Outcome code |
| is_setup | input | 1 | Token was SETUP |
| hs_ep | input | 1 | Endpoint is high speed |
| csplit | input | 1 | Transaction was a complete-split |
| hshake | input | 2 | Handshake received |
| byte_cnt | input | LEN_W | Bytes returned by the device |
| max_len | input | LEN_W | Maximum expected bytes |
| reload | input | 1 | Restore budget and clear queue flags |
| reload_cnt | input | CNT_W | Budget loaded on reload |
| sw_clr | input | 1 | Write-one clear of the interrupt status |
| err_cnt | output | CNT_W | Remaining error budget |
| xact_err | output | 1 | Transaction error flag |
| babble | output | 1 | Babble flag |
| halted | output | 1 | Queue halted |
| err_irq | output | 1 | Sticky error interrupt status |

## Verification
The bench builds the block with its defaults: a 2-bit budget and 11-bit lengths. This makes the full cross of outcome, token, speed, split and handshake small enough to sweep completely. Each case is tried with byte counts at and one past the maximum. Every budget from 0 to 3 is run down to its end, which reaches the 1-to-0 halt, unlimited mode and the clear-versus-set race.

// File: rtl/usb_xact_err_tracker.sv
module usb_xact_err_tracker #(
  parameter int CNT_W = 2,
  parameter int LEN_W = 11,
  parameter int RESET_CNT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic [2:0]       outcome,
  input  logic             is_setup,
  input  logic             hs_ep,
  input  logic             csplit,
  input  logic [1:0]       hshake,
  input  logic [LEN_W-1:0] byte_cnt,
  input  logic [LEN_W-1:0] max_len,
  input  logic             reload,
  input  logic [CNT_W-1:0] reload_cnt,
  input  logic             sw_clr,
  output logic [CNT_W-1:0] err_cnt,
  output logic             xact_err,
  output logic             babble,
  output logic             halted,
  output logic             err_irq
);
  localparam logic [2:0] OC_CRC = 3'd1, OC_TMO = 3'd2, OC_PID = 3'd3,
                         OC_HSK = 3'd4, OC_DATA = 3'd5;
  localparam logic [1:0] HS_NAK = 2'd1, HS_NYET = 2'd2;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic unlimited;
  logic live, proto_err, hard_err, is_err, is_babble, last_err;

  assign live = done && !halted && !reload;
  assign proto_err = (outcome == OC_HSK) &&
    ((is_setup && hs_ep && (hshake == HS_NAK || hshake == HS_NYET)) ||
     (!hs_ep && csplit && hshake == HS_NAK));
  assign hard_err  = (outcome == OC_CRC) || (outcome == OC_TMO) || (outcome == OC_PID);
  assign is_err    = live && (hard_err || proto_err);
  assign is_babble = live && (outcome == OC_DATA) && (byte_cnt > max_len);
  assign last_err  = is_err && !unlimited && (err_cnt == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_cnt   <= CNT_W'(RESET_CNT);
      unlimited <= (RESET_CNT == 0);
      xact_err  <= 1'b0;
      babble    <= 1'b0;
      halted    <= 1'b0;
    end else if (reload) begin
      err_cnt   <= reload_cnt;
      unlimited <= (reload_cnt == '0);
      xact_err  <= 1'b0;
      babble    <= 1'b0;
      halted    <= 1'b0;
    end else begin
      if (is_err) begin
        xact_err <= 1'b1;
        if (!unlimited) err_cnt <= err_cnt - ONE;
      end
      if (is_babble) babble <= 1'b1;
      if (is_babble || last_err) halted <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_irq <= 1'b0;
    else        err_irq <= last_err || (err_irq && !sw_clr);
  end
endmodule

module usb_xact_err_tracker_chk #(
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reload,
  input logic             sw_clr,
  input logic [CNT_W-1:0] err_cnt,
  input logic             babble,
  input logic             halted,
  input logic             err_irq
);
  a_r4_irq_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_irq) |-> ($past(err_cnt) == CNT_W'(1) && err_cnt == '0 && halted));
  a_r5_babble_no_dec: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(babble) |-> ($stable(err_cnt) && halted));
  a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_irq && !sw_clr) |=> err_irq);
  a_r8_halt_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !reload) |=> ($stable(err_cnt) && halted));
  a_r1_cnt_never_up: assert property (@(posedge clk) disable iff (!rst_n)
    !reload |=> (err_cnt <= $past(err_cnt)));
endmodule

bind usb_xact_err_tracker usb_xact_err_tracker_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reload(reload), .sw_clr(sw_clr),
  .err_cnt(err_cnt), .babble(babble), .halted(halted), .err_irq(err_irq));

// File: tb/usb_xact_err_tracker_bench.sv
module usb_xact_err_tracker_bench;
  localparam int CLK_NS = 10;
  logic clk = 0, rst_n = 0;
  logic done = 0, is_setup = 0, hs_ep = 0, csplit = 0, reload = 0, sw_clr = 0;
  logic [2:0] outcome = 0;
  logic [1:0] hshake = 0, reload_cnt = 0;
  logic [10:0] byte_cnt = 0, max_len = 0;
  logic [1:0] err_cnt;
  logic xact_err, babble, halted, err_irq;
  int n_chk = 0, n_bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  usb_xact_err_tracker u_usb_xact_err_tracker (.*);

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic state(string req, int c, int x, int b, int h, int i);
    chk({req, " cnt"}, err_cnt, c);
    chk({req, " xerr"}, xact_err, x);
    chk({req, " babble"}, babble, b);
    chk({req, " halted"}, halted, h);
    chk({req, " irq"}, err_irq, i);
  endtask

  task automatic load(int v);
    @(negedge clk); reload = 1; reload_cnt = 2'(v);
    @(negedge clk); reload = 0;
  endtask

  task automatic xact(int oc, int st, int hs, int cs, int hk, int bc, int ml, int clr);
    @(negedge clk);
    done = 1; outcome = 3'(oc); is_setup = st[0]; hs_ep = hs[0]; csplit = cs[0];
    hshake = 2'(hk); byte_cnt = 11'(bc); max_len = 11'(ml); sw_clr = clr[0];
    @(negedge clk); done = 0; sw_clr = 0;
  endtask

  task automatic clear_irq();
    @(negedge clk); sw_clr = 1; @(negedge clk); sw_clr = 0;
  endtask

  initial begin
    #(CLK_NS * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    state("R10 reset", 3, 0, 0, 0, 0);
    rst_n = 1;
    @(negedge clk);
    state("R10 after release", 3, 0, 0, 0, 0);

    // R1 R2 R3 R5 R6 exhaustive sweep
    for (int oc = 0; oc < 8; oc++)
      for (int st = 0; st < 2; st++)
        for (int hs = 0; hs < 2; hs++)
          for (int cs = 0; cs < 2; cs++)
            for (int hk = 0; hk < 4; hk++)
              for (int ov = 0; ov < 2; ov++) begin
                bit e, b;
                string tag;
                e = (oc >= 1 && oc <= 3) ||
                    (oc == 4 && ((st == 1 && hs == 1 && (hk == 1 || hk == 2)) ||
                                 (hs == 0 && cs == 1 && hk == 1)));
                b = (oc == 5) && ov == 1;
                tag = (oc >= 1 && oc <= 3) ? "R1" : (oc == 4) ? "R2/R3" :
                      (oc == 5) ? "R5" : "R6";
                load(3);
                xact(oc, st, hs, cs, hk, 64 + ov, 64, 0);
                state(tag, e ? 2 : 3, int'(e), int'(b), int'(b), 0);
              end

    // R4 countdown for each limited budget
    for (int v = 1; v < 4; v++) begin
      load(v);
      for (int k = 1; k <= v; k++) begin
        xact(2, 0, 0, 0, 0, 0, 0, 0);
        state("R4 countdown", v - k, 1, 0, int'(k == v), int'(k == v));
      end
      // R8 halted ignores outcomes
      xact(1, 0, 0, 0, 0, 0, 0, 0);
      xact(5, 0, 0, 0, 0, 9, 1, 0);
      state("R8 halted ignore", 0, 1, 0, 1, 1);
      // R7 sticky across reload, then cleared by software
      load(2);
      state("R8 reload clears", 2, 0, 0, 0, 1);
      clear_irq();
      chk("R7 w1c", err_irq, 0);
    end

    // R8 reload beats completion in same cycle
    @(negedge clk); reload = 1; reload_cnt = 1; done = 1; outcome = 1;
    @(negedge clk); reload = 0; done = 0;
    state("R8 reload priority", 1, 0, 0, 0, 0);

    // R7 clear and set in same cycle: set wins
    xact(3, 0, 0, 0, 0, 0, 0, 1);
    state("R7 set wins", 0, 1, 0, 1, 1);
    load(3);
    repeat (3) @(negedge clk);
    chk("R7 holds", err_irq, 1);
    clear_irq();

    // R9 unlimited budget
    load(0);
    for (int k = 0; k < 6; k++) xact(1 + k % 3, 0, 0, 0, 0, 0, 0, 0);
    state("R9 unlimited", 0, 1, 0, 0, 0);
    xact(5, 0, 0, 0, 0, 10, 9, 0);
    state("R9 babble still halts", 0, 1, 1, 1, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule